// File: doc/BRIEF.md
# Last-Level Address Invalidation Engine for a Translation Cache

This block holds a small, fully associative array of cached address translations. It has a fill port that writes one entry per cycle and a maintenance port that removes entries by virtual address. Each entry records the following:

- a valid bit
- whether it is a first-stage translation
- whether it is global
- a 16-bit address-space identifier (ASID)
- the virtual page number for address bits 55 down to 12
- the granule size
- the walk level its leaf came from
- whether it is a final-level (leaf) entry

A 64-bit maintenance operand is decoded once. It is then compared against every stored entry in parallel. All matching entries are cleared at a single clock edge, and a one-cycle completion pulse follows.

The operand can carry a level hint. A usable hint narrows removal to entries whose granule and leaf level equal the hint. A missing or reserved hint matches on address and ASID alone. Table descriptors cached as non-leaf entries and second-stage entries are never disturbed. An 8-bit ASID mode clears the upper operand ASID byte before the compare.

Top module: `tlbinv_engine`

## Requirements
- R1: While reset is asserted, and after it is released, every entry reads as invalid on `entry_valid` and `done` is low.
- R2: A fill writes all fields of the selected entry and marks it valid. The new state is visible on `entry_valid` after the next rising edge.
- R3: An invalidate can remove only an entry that meets all of these conditions:
  - it is valid;
  - it is a first-stage entry (`fill_stage1`=1);
  - it is a leaf (`fill_leaf`=1);
  - its page covers operand bits [43:0], which carry VA[55:12].
  Non-leaf and second-stage entries stay valid.
- R4: A global entry matches whatever the operand ASID in bits [63:48]. A non-global entry also needs its stored ASID to equal that field exactly.
- R5: Granule codes are 01 = 4KB, 10 = 16KB and 11 = 64KB. For a 16KB entry the compare ignores address bits [1:0]. For a 64KB entry it ignores bits [3:0]. For a 4KB entry all 44 bits are compared.
- R6: Hint bits [47:46] equal to 00 mean no hint. No entry is filtered by the hint, and hint bits [45:44] are ignored.
- R7: A usable hint gives a granule in bits [47:46] (same codes as R5) and a level in bits [45:44] (01, 10 or 11 = level 1, 2 or 3). Only entries whose stored granule and level both equal the hint are removed.
- R8: Reserved hints are treated exactly as no hint. These are level code 00 with any granule, and level 01 with the 16KB granule.
- R9: With `asid_narrow`=1, operand bits [63:56] are taken as zero before the ASID compare.
- R10: Entries are cleared at the rising edge that samples `inv_req`. `done` is high for exactly the following cycle.
- R11: A fill presented in the same cycle as `inv_req` is discarded and leaves the entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Write an entry this cycle |
| fill_idx | input | IDX_W | Entry index to write |
| fill_stage1 | input | 1 | Entry is a first-stage translation |
| fill_global | input | 1 | Entry is global |
| fill_asid | input | 16 | Entry ASID |
| fill_vpn | input | 44 | Entry VA[55:12] |
| fill_gran | input | 2 | Entry granule code |
| fill_level | input | 2 | Walk level of the entry |
| fill_leaf | input | 1 | Entry comes from the final lookup level |
| inv_req | input | 1 | Perform an invalidate this cycle |
| inv_operand | input | 64 | ASID, hint and VA[55:12] |
| asid_narrow | input | 1 | Use 8-bit ASIDs |
| entry_valid | output | NUM_ENTRIES | Valid bit of each entry |
| done | output | 1 | Invalidate completion pulse |

## Verification
The state of each entry changes at the rising edge that samples the request. The completion pulse is registered at that same edge, so both results are due one cycle after the stimulus. The scoreboard therefore samples them at the falling edge that follows the accepting rising edge.

The driver computes the expected valid vector from a bench-side model and queues it before it raises the request. The monitor pops that vector only while `done` is high. A pulse with nothing queued, or a pulse that lasts longer than one cycle, is reported as an error.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
  localparam int ASID_W = 16;
  localparam int VPN_W  = 44;
  localparam int OP_W   = 64;

  typedef enum logic [1:0] {
    GR_NONE = 2'b00,
    GR_4K   = 2'b01,
    GR_16K  = 2'b10,
    GR_64K  = 2'b11
  } gran_e;

  typedef struct packed {
    logic              valid;
    logic              stage1;
    logic              glob;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    gran_e             gran;
    logic [1:0]        level;
    logic              leaf;
  } tlb_entry_t;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic              hint_on;
    gran_e             hint_gran;
    logic [1:0]        hint_level;
    logic [VPN_W-1:0]  vpn;
  } inv_cmd_t;

  // Address bits that take part in the compare for a given granule
  function automatic logic [VPN_W-1:0] page_mask(gran_e g);
    logic [VPN_W-1:0] m;
    m = '1;
    case (g)
      GR_16K:  m[1:0] = 2'b00;
      GR_64K:  m[3:0] = 4'b0000;
      default: m = '1;
    endcase
    return m;
  endfunction

  // A hint filters only when it names a granule and a non-reserved level
  function automatic logic hint_usable(logic [3:0] h);
    return (h[3:2] != 2'b00) && (h[1:0] != 2'b00) &&
           !((h[3:2] == 2'b10) && (h[1:0] == 2'b01));
  endfunction
endpackage

// File: rtl/tlbinv_decode.sv
module tlbinv_decode
  import tlbinv_pkg::*;
(
  input  logic [OP_W-1:0] operand,
  input  logic            narrow,
  output inv_cmd_t        cmd
);
  localparam int ASID_LSB = OP_W - ASID_W;
  localparam int HINT_LSB = VPN_W;

  logic [3:0]        hint;
  logic [ASID_W-1:0] raw_asid;

  assign hint     = operand[HINT_LSB +: 4];
  assign raw_asid = operand[ASID_LSB +: ASID_W];

  always_comb begin
    cmd            = '0;
    cmd.vpn        = operand[VPN_W-1:0];
    cmd.asid       = raw_asid;
    if (narrow) cmd.asid[ASID_W-1:ASID_W/2] = '0;
    cmd.hint_on    = hint_usable(hint);
    cmd.hint_gran  = gran_e'(hint[3:2]);
    cmd.hint_level = hint[1:0];
  end
endmodule

// File: rtl/tlbinv_match.sv
module tlbinv_match
  import tlbinv_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  tlb_entry_t             ents [NUM_ENTRIES],
  input  inv_cmd_t               cmd,
  output logic [NUM_ENTRIES-1:0] hit
);
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
    logic [VPN_W-1:0] msk;
    logic addr_ok, asid_ok, hint_ok, kind_ok;
    assign msk     = page_mask(ents[i].gran);
    assign addr_ok = ((ents[i].vpn ^ cmd.vpn) & msk) == '0;
    assign asid_ok = ents[i].glob || (ents[i].asid == cmd.asid);
    assign hint_ok = !cmd.hint_on ||
                     ((ents[i].gran == cmd.hint_gran) && (ents[i].level == cmd.hint_level));
    assign kind_ok = ents[i].valid && ents[i].stage1 && ents[i].leaf;
    assign hit[i]  = kind_ok && addr_ok && asid_ok && hint_ok;
  end
endmodule

// File: rtl/tlbinv_engine.sv
module tlbinv_engine
  import tlbinv_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fill_en,
  input  logic [IDX_W-1:0]       fill_idx,
  input  logic                   fill_stage1,
  input  logic                   fill_global,
  input  logic [15:0]            fill_asid,
  input  logic [43:0]            fill_vpn,
  input  logic [1:0]             fill_gran,
  input  logic [1:0]             fill_level,
  input  logic                   fill_leaf,
  input  logic                   inv_req,
  input  logic [63:0]            inv_operand,
  input  logic                   asid_narrow,
  output logic [NUM_ENTRIES-1:0] entry_valid,
  output logic                   done
);
  tlb_entry_t             ents [NUM_ENTRIES];
  tlb_entry_t             fill_ent;
  inv_cmd_t               cmd;
  logic [NUM_ENTRIES-1:0] hit;
  logic [NUM_ENTRIES-1:0] leaf_s1_vec;
  logic                   fill_take;

  assign fill_take = fill_en && !inv_req;

  always_comb begin
    fill_ent        = '0;
    fill_ent.valid  = 1'b1;
    fill_ent.stage1 = fill_stage1;
    fill_ent.glob   = fill_global;
    fill_ent.asid   = fill_asid;
    fill_ent.vpn    = fill_vpn;
    fill_ent.gran   = gran_e'(fill_gran);
    fill_ent.level  = fill_level;
    fill_ent.leaf   = fill_leaf;
  end

  tlbinv_decode u_dec (
    .operand (inv_operand),
    .narrow  (asid_narrow),
    .cmd     (cmd)
  );

  tlbinv_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .ents (ents),
    .cmd  (cmd),
    .hit  (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) ents[i] <= '0;
      done <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (inv_req && hit[i])
          ents[i].valid <= 1'b0;
        else if (fill_take && (fill_idx == IDX_W'(i)))
          ents[i] <= fill_ent;
      end
      done <= inv_req;
    end
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_out
    assign entry_valid[i] = ents[i].valid;
    assign leaf_s1_vec[i] = ents[i].leaf && ents[i].stage1;

    // R3
    hit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_req && hit[i]) |=> !entry_valid[i]);
  end

  // R3
  leaf_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & ~leaf_s1_vec) == '0);

  // R10
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |=> done);

  // R11
  no_fill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_req |=> ((entry_valid & $past(entry_valid)) == $past(entry_valid)));

  // R11
  fill_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && fill_en && !entry_valid[fill_idx]) |=> !entry_valid[$past(fill_idx)]);
endmodule

// File: tb/tb_tlbinv_engine.sv
`timescale 1ns/1ps
module tb_tlbinv_engine;
  localparam int N = 8;
  localparam logic [43:0] VA_A = 44'h00012345678;
  localparam logic [43:0] VA_B = 44'h000ABCDEF00;
  localparam logic [43:0] VA_C = 44'h00055550000;
  localparam logic [43:0] VA_D = 44'h00099990040;

  logic clk = 0, rst_n = 0;
  logic fill_en = 0, fill_stage1 = 0, fill_global = 0, fill_leaf = 0;
  logic [2:0] fill_idx = 0;
  logic [15:0] fill_asid = 0;
  logic [43:0] fill_vpn = 0;
  logic [1:0] fill_gran = 0, fill_level = 0;
  logic inv_req = 0, asid_narrow = 0;
  logic [63:0] inv_operand = 0;
  logic [N-1:0] entry_valid;
  logic done;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  // bench-side model
  bit          m_v [N];
  bit          m_s1 [N];
  bit          m_g [N];
  bit          m_leaf [N];
  logic [15:0] m_asid [N];
  logic [43:0] m_vpn [N];
  logic [1:0]  m_gran [N];
  logic [1:0]  m_lvl [N];

  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  bit           done_prev = 0;

  always #2.5 clk = ~clk;

  tlbinv_engine #(.NUM_ENTRIES(N)) dut (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_idx(fill_idx),
    .fill_stage1(fill_stage1), .fill_global(fill_global), .fill_asid(fill_asid),
    .fill_vpn(fill_vpn), .fill_gran(fill_gran), .fill_level(fill_level),
    .fill_leaf(fill_leaf), .inv_req(inv_req), .inv_operand(inv_operand),
    .asid_narrow(asid_narrow), .entry_valid(entry_valid), .done(done)
  );

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_v[i];
    return v;
  endfunction

  // Expected removal, written as shift-and-compare rather than masking
  function automatic bit m_hit(int i, logic [63:0] op, bit narrow);
    logic [15:0] a;
    logic [1:0] tg, lv;
    int sh;
    bit addr, info;
    a = op[63:48];
    if (narrow) a[15:8] = 8'h00;
    tg = op[47:46];
    lv = op[45:44];
    sh = (m_gran[i] == 2'd2) ? 2 : (m_gran[i] == 2'd3) ? 4 : 0;
    addr = (m_vpn[i] >> sh) == (op[43:0] >> sh);
    info = (tg != 0) && (lv != 0) && !(tg == 2'd2 && lv == 2'd1);
    return m_v[i] && m_s1[i] && m_leaf[i] && addr &&
           (m_g[i] || m_asid[i] == a) &&
           (!info || (tg == m_gran[i] && lv == m_lvl[i]));
  endfunction

  task automatic fill(int idx, bit s1, bit g, logic [15:0] asid, logic [43:0] vpn,
                      logic [1:0] gr, logic [1:0] lvl, bit leaf);
    @(negedge clk);
    fill_en = 1; fill_idx = 3'(idx); fill_stage1 = s1; fill_global = g;
    fill_asid = asid; fill_vpn = vpn; fill_gran = gr; fill_level = lvl; fill_leaf = leaf;
    m_v[idx] = 1; m_s1[idx] = s1; m_g[idx] = g; m_asid[idx] = asid;
    m_vpn[idx] = vpn; m_gran[idx] = gr; m_lvl[idx] = lvl; m_leaf[idx] = leaf;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic refill_all();
    fill(0, 1, 1, 16'h0000, VA_A, 2'd1, 2'd3, 1);
    fill(1, 1, 0, 16'h0005, VA_A, 2'd1, 2'd3, 1);
    fill(2, 1, 0, 16'h0006, VA_A, 2'd1, 2'd3, 1);
    fill(3, 1, 0, 16'h0005, VA_B, 2'd2, 2'd2, 1);
    fill(4, 1, 1, 16'h0000, VA_C, 2'd3, 2'd3, 1);
    fill(5, 1, 1, 16'h0000, VA_A, 2'd1, 2'd2, 0);
    fill(6, 0, 1, 16'h0000, VA_A, 2'd1, 2'd3, 1);
    fill(7, 1, 0, 16'h0007, VA_D, 2'd1, 2'd3, 1);
  endtask

  // Driver: push expected state, then present the request for one cycle
  task automatic inv(logic [15:0] asid, logic [3:0] hint, logic [43:0] va,
                     bit narrow, string tag, bit with_fill = 0);
    logic [63:0] op;
    logic [N-1:0] hits;
    op = {asid, hint, va};
    for (int i = 0; i < N; i++) hits[i] = m_hit(i, op, narrow);
    for (int i = 0; i < N; i++) if (hits[i]) m_v[i] = 0;
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
    @(negedge clk);
    inv_req = 1; inv_operand = op; asid_narrow = narrow;
    if (with_fill) begin
      fill_en = 1; fill_idx = 3'd2; fill_stage1 = 1; fill_global = 1;
      fill_vpn = VA_A; fill_gran = 2'd1; fill_level = 2'd3; fill_leaf = 1;
    end
    @(negedge clk);
    inv_req = 0; fill_en = 0; asid_narrow = 0;
    @(negedge clk);
  endtask

  // Monitor: results are due one cycle after the request
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin
        if (done_prev) check(0, "R10 done wider than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          check(0, "R10 done without request", 1, 0);
        end else begin
          logic [N-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(entry_valid == e, t, 64'(entry_valid), 64'(e));
        end
      end
      done_prev = done;
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      report();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_s1[i] = 0; m_g[i] = 0; m_leaf[i] = 0;
      m_asid[i] = 0; m_vpn[i] = 0; m_gran[i] = 0; m_lvl[i] = 0;
    end
    repeat (3) @(negedge clk);
    check(entry_valid == '0 && done == 0, "R1 reset state", {entry_valid, 7'b0, done}, 0);
    rst_n = 1;
    @(negedge clk);
    check(entry_valid == '0 && done == 0, "R1 after reset", {entry_valid, 7'b0, done}, 0);

    refill_all();
    check(entry_valid == model_vec(), "R2 fill sets valid", 64'(entry_valid), 64'(model_vec()));

    inv(16'h0005, 4'h0, VA_A, 0, "R3 R4 no hint asid 5 at VA_A");
    inv(16'h0006, 4'h0, VA_A ^ 44'h1, 0, "R5 4KB entry needs all bits");
    inv(16'h0005, 4'h0, VA_B | 44'h3, 0, "R5 16KB ignores low two bits");
    inv(16'h0000, 4'h0, VA_C | 44'hF, 0, "R5 64KB ignores low four bits");

    refill_all();
    inv(16'h0005, 4'b0111, VA_A, 0, "R7 hint 4KB level 3 removes");
    inv(16'h0006, 4'b0110, VA_A, 0, "R7 hint 4KB level 2 keeps");
    inv(16'h0005, 4'b1011, VA_B, 0, "R7 hint 16KB level 3 keeps level 2 entry");
    inv(16'h0005, 4'b1001, VA_B, 0, "R8 16KB level 1 reserved");
    inv(16'h0000, 4'b1111, VA_C | 44'h5, 0, "R7 hint 64KB level 3");

    refill_all();
    inv(16'h0006, 4'b1100, VA_A, 0, "R8 level 00 reserved");
    inv(16'h0005, 4'b0010, VA_A, 0, "R6 no granule ignores level bits");
    inv(16'hAB07, 4'h0, VA_D, 0, "R9 full width asid mismatch");
    inv(16'hAB07, 4'h0, VA_D, 1, "R9 narrow asid match");

    inv(16'h0000, 4'h0, VA_C, 0, "R11 fill during invalidate discarded", 1);
    check(entry_valid[2] == 0, "R11 entry 2 unchanged", 64'(entry_valid[2]), 0);
    check(done == 0, "R10 done low after pulse", 64'(done), 0);
    check(exp_q.size() == 0, "R10 every request completed", exp_q.size(), 0);

    report();
  end
endmodule